// File: doc/BRIEF.md
# Load/Store Issue Scheduler

This block tracks memory operations in an ordered queue from dispatch until retirement. Each cycle it decides which entry computes its effective address and which load may read memory. Loads and stores enter in program order at the tail. Each one arrives with its full address. It also carries two wait counts: one for its address operand and, for stores, one for its store data. A count of zero means the operand is ready in the dispatch cycle.

A single mode input selects how loads are treated around older stores. In the conservative mode, a load waits until every older store has resolved its address. In the speculative mode, a load ignores older stores whose addresses are still unknown. When such a store later resolves to the load's address, the load is flagged for replay and reads memory again.

Stores never write memory early. A store writes memory only when it reaches the head of the queue and the commit input allows it.

Top module: `lsq_sched`

## Requirements
- R1: An entry dispatched in cycle c with address wait count L computes its address no earlier than cycle c+L+1. It computes it exactly once.
- R2: A load's memory access comes no earlier than the cycle after its address calculation.
- R3: A store never receives a memory-access grant. It writes memory (`st_write` high, with `st_idx` naming its slot) only when all of the following hold:
  - it is at the head of the queue;
  - its address is computed;
  - its data wait has expired;
  - `commit` is high.
- R4: With `predict_en` low, a load does not access memory while any older store in the queue has an uncomputed address.
- R5: With `predict_en` high, a load whose address is computed may access memory even though older stores still have unknown addresses.
- R6: A load whose full address equals that of an older store with a computed address does not access memory until that store has left the queue.
- R7: When a store computes its address and a younger load with the same full address has already accessed memory (or is being granted access in that cycle), the block does the following:
  - `replay_valid` pulses in that cycle, with `replay_idx` naming the oldest such load;
  - the load accesses memory again later.
- R8: At most one address calculation and one memory access are granted per cycle. Each goes to the oldest eligible entry.
- R9: Slots are allocated in order starting from slot 0 after reset. `full` is high when the queue holds DEPTH entries, and a dispatch offered while `full` is high is discarded. A load retires from the head one cycle after its memory access; a store retires in its write cycle.
- R10: During reset the queue is empty: `full`, `agen_valid`, `mem_valid`, `st_write` and `replay_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| predict_en | input | 1 | 1 = speculative loads, 0 = conservative |
| disp_valid | input | 1 | Dispatch request |
| disp_store | input | 1 | Dispatched entry is a store |
| disp_addr | input | AW | Full memory address of the entry |
| disp_alat | input | LW | Cycles until the address operand is ready |
| disp_dlat | input | LW | Cycles until store data is ready |
| full | output | 1 | Queue holds DEPTH entries |
| agen_valid | output | 1 | Address calculation granted this cycle |
| agen_idx | output | log2(DEPTH) | Slot granted address calculation |
| mem_valid | output | 1 | Load memory access granted this cycle |
| mem_idx | output | log2(DEPTH) | Slot granted memory access |
| commit | input | 1 | Permits the head store to write memory |
| st_write | output | 1 | Head store writes memory and retires |
| st_idx | output | log2(DEPTH) | Slot of the writing store |
| replay_valid | output | 1 | A load was found to have read stale memory |
| replay_idx | output | log2(DEPTH) | Oldest load flagged for replay |

## Verification
The bench builds the block with DEPTH=4, AW=8 and LW=4. The same four-entry program is run in both modes: a load, a late-resolving store, an unrelated load, and a load aliasing the store. Four slots let that program fill the queue, so a fifth dispatch is offered while `full` is high. The short wait counts make two entries become ready for address calculation in the same cycle, which exercises oldest-first arbitration. Exact 8-bit addresses give one aliasing pair that blocks the load in conservative mode and forces a replay in speculative mode.

// File: rtl/lsq_sched.sv
module lsq_sched #(
  parameter int DEPTH = 8,
  parameter int AW = 32,
  parameter int LW = 4,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          predict_en,
  input  logic          disp_valid,
  input  logic          disp_store,
  input  logic [AW-1:0] disp_addr,
  input  logic [LW-1:0] disp_alat,
  input  logic [LW-1:0] disp_dlat,
  output logic          full,
  output logic          agen_valid,
  output logic [IW-1:0] agen_idx,
  output logic          mem_valid,
  output logic [IW-1:0] mem_idx,
  input  logic          commit,
  output logic          st_write,
  output logic [IW-1:0] st_idx,
  output logic          replay_valid,
  output logic [IW-1:0] replay_idx
);
  logic [DEPTH-1:0] vld, st, adone, acc;
  logic [AW-1:0]    addr [DEPTH];
  logic [LW-1:0]    aw [DEPTH];
  logic [LW-1:0]    dw [DEPTH];
  logic [IW-1:0]    head, tail;
  logic [IW:0]      cnt;
  logic [DEPTH-1:0] ag_el, mem_el, blk, viol;
  logic             push, retire;

  function automatic logic older(input logic [IW-1:0] j, input logic [IW-1:0] i,
                                 input logic [IW-1:0] h);
    logic [IW-1:0] aj, ai;
    aj = j - h;
    ai = i - h;
    return aj < ai;
  endfunction

  assign full   = (cnt == (IW+1)'(DEPTH));
  assign push   = disp_valid && !full;
  assign retire = vld[head] && (st[head] ? (adone[head] && dw[head] == '0 && commit)
                                         : acc[head]);
  assign st_write = retire && st[head];
  assign st_idx   = head;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      blk[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (vld[j] && st[j] && older(IW'(j), IW'(i), head))
          if ((adone[j] && addr[j] == addr[i]) || (!predict_en && !adone[j]))
            blk[i] = 1'b1;
      ag_el[i]  = vld[i] && !adone[i] && aw[i] == '0;
      mem_el[i] = vld[i] && !st[i] && adone[i] && !acc[i] && !blk[i];
    end
  end

  always_comb begin
    logic [IW-1:0] p;
    agen_valid = 1'b0;
    agen_idx   = '0;
    mem_valid  = 1'b0;
    mem_idx    = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      p = head + IW'(k);
      if (ag_el[p]) begin
        agen_valid = 1'b1;
        agen_idx   = p;
      end
      if (mem_el[p]) begin
        mem_valid = 1'b1;
        mem_idx   = p;
      end
    end
  end

  always_comb begin
    logic [IW-1:0] p;
    for (int i = 0; i < DEPTH; i++)
      viol[i] = agen_valid && st[agen_idx] && vld[i] && !st[i]
             && older(agen_idx, IW'(i), head) && addr[agen_idx] == addr[i]
             && (acc[i] || (mem_valid && mem_idx == IW'(i)));
    replay_valid = |viol;
    replay_idx   = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      p = head + IW'(k);
      if (viol[p]) replay_idx = p;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      st    <= '0;
      adone <= '0;
      acc   <= '0;
      head  <= '0;
      tail  <= '0;
      cnt   <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (agen_valid && agen_idx == IW'(i)) adone[i] <= 1'b1;
        if (mem_valid && mem_idx == IW'(i))   acc[i]   <= 1'b1;
        if (viol[i])                          acc[i]   <= 1'b0;
      end
      if (retire) begin
        vld[head] <= 1'b0;
        head      <= head + 1'b1;
      end
      if (push) begin
        vld[tail]   <= 1'b1;
        st[tail]    <= disp_store;
        adone[tail] <= 1'b0;
        acc[tail]   <= 1'b0;
        tail        <= tail + 1'b1;
      end
      cnt <= cnt + (IW+1)'(push) - (IW+1)'(retire);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (aw[i] != '0) aw[i] <= aw[i] - 1'b1;
      if (dw[i] != '0) dw[i] <= dw[i] - 1'b1;
    end
    if (push) begin
      addr[tail] <= disp_addr;
      aw[tail]   <= disp_alat;
      dw[tail]   <= disp_dlat;
    end
  end
endmodule

module lsq_sched_chk #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IW:0]      cnt,
  input logic [DEPTH-1:0] st,
  input logic [IW-1:0]    head,
  input logic             agen_valid,
  input logic [IW-1:0]    agen_idx,
  input logic             mem_valid,
  input logic [IW-1:0]    mem_idx,
  input logic             st_write,
  input logic [IW-1:0]    st_idx,
  input logic             replay_valid,
  input logic [IW-1:0]    replay_idx
);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (IW+1)'(DEPTH));
  p_store_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !st[mem_idx]);
  p_write_at_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    st_write |-> (st_idx == head && st[st_idx]));
  p_agen_then_mem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (agen_valid && mem_valid) |-> agen_idx != mem_idx);
  p_agen_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    agen_valid |=> !(agen_valid && agen_idx == $past(agen_idx)));
  p_replay_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |=> !(mem_valid && mem_idx == $past(replay_idx)));
endmodule

bind lsq_sched lsq_sched_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .st(st), .head(head),
  .agen_valid(agen_valid), .agen_idx(agen_idx),
  .mem_valid(mem_valid), .mem_idx(mem_idx),
  .st_write(st_write), .st_idx(st_idx),
  .replay_valid(replay_valid), .replay_idx(replay_idx));

// File: tb/tb_lsq_sched.sv
module tb_lsq_sched;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int IW = $clog2(DEPTH);
  localparam int NCYC = 16;

  // {store, addr, address wait, data wait}; row 4 is offered while full
  localparam logic [16:0] STIM [5] = '{
    {1'b0, 8'h10, 4'd3, 4'd0},
    {1'b1, 8'h20, 4'd5, 4'd1},
    {1'b0, 8'h30, 4'd0, 4'd0},
    {1'b0, 8'h20, 4'd0, 4'd0},
    {1'b0, 8'h50, 4'd0, 4'd0}
  };
  localparam int EXP_AG [4] = '{4, 7, 3, 5};
  localparam int EXP_MF [2][4] = '{'{5, -1, 8, 9}, '{5, -1, 4, 6}};
  localparam int EXP_ML [2][4] = '{'{5, -1, 8, 9}, '{5, -1, 4, 9}};
  localparam int EXP_NM [2] = '{3, 4};
  localparam int EXP_RP [2] = '{0, 1};

  logic clk = 1'b0, rst_n = 1'b0, predict_en = 1'b0;
  logic disp_valid = 1'b0, disp_store = 1'b0, commit = 1'b1;
  logic [AW-1:0] disp_addr = '0;
  logic [LW-1:0] disp_alat = '0, disp_dlat = '0;
  logic full, agen_valid, mem_valid, st_write, replay_valid;
  logic [IW-1:0] agen_idx, mem_idx, st_idx, replay_idx;

  int checks = 0, failures = 0;
  int ag [4], mf [4], ml [4];
  int nag, nmem, nrp, stc, sts, rpc, rps, fullv, idle;

  always #10 clk = ~clk;

  lsq_sched #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .predict_en(predict_en),
    .disp_valid(disp_valid), .disp_store(disp_store), .disp_addr(disp_addr),
    .disp_alat(disp_alat), .disp_dlat(disp_dlat), .full(full),
    .agen_valid(agen_valid), .agen_idx(agen_idx),
    .mem_valid(mem_valid), .mem_idx(mem_idx), .commit(commit),
    .st_write(st_write), .st_idx(st_idx),
    .replay_valid(replay_valid), .replay_idx(replay_idx));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    disp_valid = 1'b0;
    commit = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 full in reset", int'(full), 0);
    chk("R10 grants idle in reset", int'(agen_valid | mem_valid), 0);
    chk("R10 write/replay idle in reset", int'(st_write | replay_valid), 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int sc);
    predict_en = (sc == 1);
    do_reset();
    for (int s = 0; s < 4; s++) begin ag[s] = -1; mf[s] = -1; ml[s] = -1; end
    nag = 0; nmem = 0; nrp = 0; stc = -1; sts = -1; rpc = -1; rps = -1;
    fullv = -1; idle = -1;
    for (int k = 0; k < NCYC; k++) begin
      @(negedge clk);
      disp_valid = (k < 5);
      if (k < 5) {disp_store, disp_addr, disp_alat, disp_dlat} = STIM[k];
      #1;
      if (agen_valid) begin
        if (ag[agen_idx] == -1) ag[agen_idx] = k;
        nag++;
      end
      if (mem_valid) begin
        if (mf[mem_idx] == -1) mf[mem_idx] = k;
        ml[mem_idx] = k;
        nmem++;
      end
      if (st_write) begin stc = k; sts = int'(st_idx); end
      if (replay_valid) begin rpc = k; rps = int'(replay_idx); nrp++; end
      if (k == 4) fullv = int'(full);
      if (k == NCYC - 1) idle = int'(agen_valid | mem_valid | full);
    end
    disp_valid = 1'b0;
    for (int s = 0; s < 4; s++) begin
      chk($sformatf("R1 R8 agen cycle slot%0d mode%0d", s, sc), ag[s], EXP_AG[s]);
      chk($sformatf("R2 R4 R5 R6 first access slot%0d mode%0d", s, sc), mf[s], EXP_MF[sc][s]);
      chk($sformatf("R6 R7 last access slot%0d mode%0d", s, sc), ml[s], EXP_ML[sc][s]);
    end
    chk("R1 R9 agen count, rejected dispatch absent", nag, 4);
    chk("R2 memory grant count", nmem, EXP_NM[sc]);
    chk("R3 store write cycle", stc, 8);
    chk("R3 store write slot", sts, 1);
    chk("R9 full after four dispatches", fullv, 1);
    chk("R9 drained and idle", idle, 0);
    chk("R7 replay count", nrp, EXP_RP[sc]);
    if (sc == 1) begin
      chk("R7 replay cycle", rpc, 7);
      chk("R7 replay slot", rps, 3);
    end
  endtask

  initial begin
    run(0);
    run(1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule